// File: doc/BRIEF.md
# Conditional Subroutine-Call Sequencer

This block carries out the program-counter and return-stack part of a conditional call instruction inside a small processor core. On each cycle where `valid_i` is high, one call instruction executes. The outcome depends on `cond_i`, the already-evaluated condition.

When the condition holds, the block saves a return frame on an internal hardware stack and loads the program counter with the call target. The frame holds the return address and the status word. When the condition does not hold, the block steps the program counter past the instruction and any extension word. The target comes from one of two sources. In full mode it is the effective address `ea_i`. In short mode it is a 15-bit immediate, extended by its sign bit.

The block also does two things that do not depend on the condition. It applies any address-register update carried by the instruction, taken or not. It raises the exception flags of a non-aware condition that meets a NaN before the frame is formed, so that the saved status word already carries those flags. A pop port exists only so that the stack contents can be inspected.

Top module: `jsr_seq`

## Requirements
- R1: When `valid_i` and `cond_i` are high and the stack holds fewer than 15 frames, a frame is pushed and depth rises by one. The frame's return address is the address following the call: PC+1, or PC+2 when a full-mode extension word is present. After the edge, `top_pc_o` shows that return address.
- R2: A taken call in full mode (`short_i`=0) loads the PC with `ea_i`. A taken call in short mode (`short_i`=1) loads the PC with `imm_i` sign-extended from bit 14 to 32 bits.
- R3: When `valid_i` is high and `cond_i` is low, the PC advances by 1. It advances by 2 when `ext_i`=1 in full mode. In short mode `ext_i` is ignored. The stack depth does not change.
- R4: When `valid_i` and `areg_we_i` are high, address register `areg_sel_i` takes the value `areg_val_i`, whether the call is taken or not. The register can be read back on `areg_rdata_o` by giving its index on `areg_rsel_i`.
- R5: The saved status word is `sr_i` with its two top bits ORed with the exception flags after this cycle's update. Bits 13:0 are stored unchanged, which includes the condition-code bits 3:0.
- R6: A taken call with `nonaware_i`=1 and `nan_i`=1 sets both exception flags (`exc_o`=2'b11). Bit 0 is the invalid-operation flag and bit 1 is the unordered flag. The frame pushed in that same cycle already carries them in status bits 15:14. The flags are sticky until reset.
- R7: The exception flags are not changed by a call that is not taken, by an aware condition, or by a call made while `nan_i` is low.
- R8: A taken call while the stack holds 15 frames pushes nothing and leaves the depth at 15. It sets the sticky flag `ovf_o` and still loads the PC with the target.
- R9: When `pop_i` is high and `valid_i` is low, the top frame is removed, so frames come out in last-in, first-out order. A pop on an empty stack is ignored. A pop in a cycle where `valid_i` is high is ignored.
- R10: After reset, the PC equals `RESET_PC` (default 0) and the depth is 0. `ovf_o`, `exc_o` and all address registers are 0. `top_pc_o` and `top_sr_o` read 0 while the stack is empty.
- R11: With `valid_i` low, the PC, the flags and the address registers hold their values, whatever the other instruction inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | A call instruction executes this cycle |
| cond_i | input | 1 | The call's condition is true |
| nonaware_i | input | 1 | The selected condition is of the non-aware kind |
| nan_i | input | 1 | NaN flag from the last comparison |
| short_i | input | 1 | 1 = short 15-bit immediate target, 0 = full effective address |
| imm_i | input | 15 | Short-mode immediate target |
| ea_i | input | 32 | Full-mode effective address |
| ext_i | input | 1 | A full-mode extension word follows the opcode |
| sr_i | input | 16 | Current status register |
| areg_we_i | input | 1 | Instruction requests an address-register update |
| areg_sel_i | input | 3 | Address register to update |
| areg_val_i | input | 32 | Updated address-register value |
| pop_i | input | 1 | Remove the top stack frame (inspection only) |
| areg_rsel_i | input | 3 | Address register to read |
| pc_o | output | 32 | Program counter |
| depth_o | output | 4 | Number of frames on the stack |
| top_pc_o | output | 32 | Return address in the top frame |
| top_sr_o | output | 16 | Status word in the top frame |
| exc_o | output | 2 | Exception flags: bit 0 invalid operation, bit 1 unordered |
| ovf_o | output | 1 | Sticky stack-overflow error |
| areg_rdata_o | output | 32 | Value of the register selected by `areg_rsel_i` |

## Verification
Every result is registered once. The PC, depth, flags, top frame and address registers therefore show an instruction's effect right after the clock edge on which `valid_i` or `pop_i` was high. The top-frame outputs and the read port add only combinational logic after those registers.

The bench drives each instruction on a falling edge, lets one rising edge pass, and compares every output at the next falling edge. Expected values come from a running model kept in the bench. For requirements that say something is ignored or held, the bench compares the very next sample with the value that should have been kept.

// File: rtl/jsr_pkg.sv
package jsr_pkg;
    localparam int PC_W   = 32;
    localparam int SR_W   = 16;
    localparam int IMM_W  = 15;
    localparam int EXC_W  = 2;
    localparam int EXC_LSB = SR_W - EXC_W;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [SR_W-1:0] sr;
    } frame_t;
endpackage

// File: rtl/jsr_target.sv
module jsr_target
    import jsr_pkg::*;
(
    input  logic [PC_W-1:0]  pc_i,
    input  logic             short_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [PC_W-1:0]  ea_i,
    input  logic             ext_i,
    output logic [PC_W-1:0]  target_o,
    output logic [PC_W-1:0]  seq_o
);
    logic ext_used;

    always_comb begin
        ext_used = ext_i & ~short_i;
        seq_o    = pc_i + PC_W'(1) + PC_W'(ext_used);
        if (short_i)
            target_o = {{(PC_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
        else
            target_o = ea_i;
    end
endmodule

// File: rtl/jsr_stack.sv
module jsr_stack
    import jsr_pkg::*;
#(
    parameter int DEPTH = 15,
    localparam int SP_W  = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic            pop_i,
    input  frame_t          frame_i,
    output frame_t          top_o,
    output logic [SP_W-1:0] depth_o,
    output logic            full_o,
    output logic            empty_o
);
    frame_t          mem_q [DEPTH];
    logic [SP_W-1:0] sp_d, sp_q;
    logic [SP_W-1:0] sp_top;

    always_comb begin
        full_o  = (sp_q == SP_W'(DEPTH));
        empty_o = (sp_q == '0);
        sp_top  = sp_q - SP_W'(1);
        sp_d    = sp_q;
        if (push_i && !full_o)
            sp_d = sp_q + SP_W'(1);
        else if (pop_i && !empty_o)
            sp_d = sp_top;
        top_o   = empty_o ? '0 : mem_q[sp_top[IDX_W-1:0]];
        depth_o = sp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sp_q <= '0;
        else
            sp_q <= sp_d;
    end

    always_ff @(posedge clk) begin
        if (push_i && !full_o)
            mem_q[sp_q[IDX_W-1:0]] <= frame_i;
    end
endmodule

// File: rtl/jsr_areg.sv
module jsr_areg #(
    parameter int NUM   = 8,
    parameter int W     = 32,
    localparam int SEL_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [SEL_W-1:0] wsel_i,
    input  logic [W-1:0]     wdata_i,
    input  logic [SEL_W-1:0] rsel_i,
    output logic [W-1:0]     rdata_o
);
    logic [W-1:0] regs_q [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_reg
        logic [W-1:0] reg_d;
        always_comb begin
            reg_d = regs_q[g];
            if (we_i && (wsel_i == SEL_W'(g)))
                reg_d = wdata_i;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else
                regs_q[g] <= reg_d;
        end
    end

    assign rdata_o = regs_q[rsel_i];
endmodule

// File: rtl/jsr_seq.sv
module jsr_seq
    import jsr_pkg::*;
#(
    parameter int              DEPTH    = 15,
    parameter int              NUM_AREG = 8,
    parameter logic [31:0]     RESET_PC = 32'h0000_0000,
    localparam int             SP_W     = $clog2(DEPTH + 1),
    localparam int             ASEL_W   = (NUM_AREG > 1) ? $clog2(NUM_AREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              cond_i,
    input  logic              nonaware_i,
    input  logic              nan_i,
    input  logic              short_i,
    input  logic [14:0]       imm_i,
    input  logic [31:0]       ea_i,
    input  logic              ext_i,
    input  logic [15:0]       sr_i,
    input  logic              areg_we_i,
    input  logic [ASEL_W-1:0] areg_sel_i,
    input  logic [31:0]       areg_val_i,
    input  logic              pop_i,
    input  logic [ASEL_W-1:0] areg_rsel_i,
    output logic [31:0]       pc_o,
    output logic [SP_W-1:0]   depth_o,
    output logic [31:0]       top_pc_o,
    output logic [15:0]       top_sr_o,
    output logic [1:0]        exc_o,
    output logic              ovf_o,
    output logic [31:0]       areg_rdata_o
);
    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [EXC_W-1:0] exc;
        logic             ovf;
    } state_t;

    state_t          st_d, st_q;
    logic [PC_W-1:0] target, seq_pc;
    logic            taken, flag_hit, push, pop_en, full, empty;
    frame_t          frame, top;

    jsr_target u_target (
        .pc_i     (st_q.pc),
        .short_i  (short_i),
        .imm_i    (imm_i),
        .ea_i     (ea_i),
        .ext_i    (ext_i),
        .target_o (target),
        .seq_o    (seq_pc)
    );

    always_comb begin
        taken    = valid_i & cond_i;
        flag_hit = taken & nonaware_i & nan_i;
        push     = taken;
        pop_en   = pop_i & ~valid_i;

        st_d = st_q;
        if (flag_hit)
            st_d.exc = {EXC_W{1'b1}};
        if (taken && full)
            st_d.ovf = 1'b1;
        if (valid_i)
            st_d.pc = taken ? target : seq_pc;

        frame.pc = seq_pc;
        frame.sr = {sr_i[SR_W-1:EXC_LSB] | st_d.exc, sr_i[EXC_LSB-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc  <= RESET_PC;
            st_q.exc <= '0;
            st_q.ovf <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    jsr_stack #(.DEPTH(DEPTH)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (pop_en),
        .frame_i (frame),
        .top_o   (top),
        .depth_o (depth_o),
        .full_o  (full),
        .empty_o (empty)
    );

    jsr_areg #(.NUM(NUM_AREG), .W(PC_W)) u_areg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (valid_i & areg_we_i),
        .wsel_i  (areg_sel_i),
        .wdata_i (areg_val_i),
        .rsel_i  (areg_rsel_i),
        .rdata_o (areg_rdata_o)
    );

    assign pc_o     = st_q.pc;
    assign exc_o    = st_q.exc;
    assign ovf_o    = st_q.ovf;
    assign top_pc_o = top.pc;
    assign top_sr_o = top.sr;

    logic unused_empty;
    assign unused_empty = empty;
endmodule

// File: rtl/jsr_seq_chk.sv
module jsr_seq_chk #(
    parameter int  DEPTH    = 15,
    parameter int  NUM_AREG = 8,
    localparam int SP_W     = $clog2(DEPTH + 1),
    localparam int ASEL_W   = (NUM_AREG > 1) ? $clog2(NUM_AREG) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic              cond_i,
    input logic              nonaware_i,
    input logic              nan_i,
    input logic              short_i,
    input logic [14:0]       imm_i,
    input logic [31:0]       ea_i,
    input logic              ext_i,
    input logic              pop_i,
    input logic [31:0]       pc_o,
    input logic [SP_W-1:0]   depth_o,
    input logic [1:0]        exc_o,
    input logic              ovf_o
);
    p_push_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && cond_i && (depth_o < SP_W'(DEPTH)) |=> depth_o == $past(depth_o) + SP_W'(1));

    p_full_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && cond_i && !short_i |=> pc_o == $past(ea_i));

    p_short_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && cond_i && short_i |=> pc_o == {{17{$past(imm_i[14])}}, $past(imm_i)});

    p_seq_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !cond_i |=> pc_o == $past(pc_o) + 32'd1 + {31'd0, $past(ext_i && !short_i)});

    p_no_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !cond_i |=> $stable(depth_o));

    p_flags_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && cond_i && nonaware_i && nan_i |=> exc_o == 2'b11);

    p_flags_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && cond_i && nonaware_i && nan_i) |=> exc_o == $past(exc_o));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && cond_i && (depth_o == SP_W'(DEPTH)) |=> ovf_o && depth_o == SP_W'(DEPTH));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    p_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && !valid_i && (depth_o != '0) |=> depth_o == $past(depth_o) - SP_W'(1));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(pc_o) && !$rose(ovf_o));
endmodule

bind jsr_seq jsr_seq_chk #(.DEPTH(DEPTH), .NUM_AREG(NUM_AREG)) u_chk (.*);

// File: tb/jsr_seq_tb.sv
module jsr_seq_tb;
    localparam int DEPTH = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 0, cond_i = 0, nonaware_i = 0, nan_i = 0, short_i = 0, ext_i = 0;
    logic [14:0] imm_i = '0;
    logic [31:0] ea_i = '0, areg_val_i = '0;
    logic [15:0] sr_i = '0;
    logic        areg_we_i = 0, pop_i = 0;
    logic [2:0]  areg_sel_i = '0, areg_rsel_i = '0;
    logic [31:0] pc_o, top_pc_o, areg_rdata_o;
    logic [3:0]  depth_o;
    logic [15:0] top_sr_o;
    logic [1:0]  exc_o;
    logic        ovf_o;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_pc;
    int          m_depth;
    logic [31:0] m_spc [DEPTH];
    logic [15:0] m_ssr [DEPTH];
    logic [1:0]  m_exc;
    logic        m_ovf;
    logic [31:0] m_areg [8];

    always #4 clk = ~clk;

    jsr_seq u_dut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check({req, " pc"}, pc_o, m_pc);
        check({req, " depth"}, 32'(depth_o), 32'(m_depth));
        check({req, " top_pc"}, top_pc_o, m_depth > 0 ? m_spc[m_depth-1] : 32'd0);
        check({req, " top_sr"}, 32'(top_sr_o), m_depth > 0 ? 32'(m_ssr[m_depth-1]) : 32'd0);
        check({req, " exc"}, 32'(exc_o), 32'(m_exc));
        check({req, " ovf"}, 32'(ovf_o), 32'(m_ovf));
    endtask

    // Drive one call instruction at a falling edge; outputs compared at the next falling edge.
    task automatic exec(input logic c, input logic na, input logic nn, input logic sh,
                        input logic [14:0] imm, input logic [31:0] ea, input logic ex,
                        input logic [15:0] sr, input logic we, input logic [2:0] sel,
                        input logic [31:0] val, string req);
        logic [31:0] seq, tgt;
        valid_i = 1; cond_i = c; nonaware_i = na; nan_i = nn; short_i = sh; imm_i = imm;
        ea_i = ea; ext_i = ex; sr_i = sr; areg_we_i = we; areg_sel_i = sel; areg_val_i = val;
        seq = m_pc + 32'd1 + ((ex && !sh) ? 32'd1 : 32'd0);
        tgt = sh ? {{17{imm[14]}}, imm} : ea;
        if (c && na && nn) m_exc = 2'b11;
        if (c) begin
            if (m_depth < DEPTH) begin
                m_spc[m_depth] = seq;
                m_ssr[m_depth] = {sr[15:14] | m_exc, sr[13:0]};
                m_depth++;
            end else begin
                m_ovf = 1'b1;
            end
            m_pc = tgt;
        end else begin
            m_pc = seq;
        end
        if (we) m_areg[sel] = val;
        @(negedge clk);
        valid_i = 0; areg_we_i = 0;
        check_all(req);
    endtask

    task automatic do_pop(input logic with_valid, string req);
        pop_i = 1;
        if (with_valid) begin
            valid_i = 1; cond_i = 0; short_i = 1; ext_i = 0;
            m_pc = m_pc + 32'd1;
        end else if (m_depth > 0) begin
            m_depth--;
        end
        @(negedge clk);
        pop_i = 0; valid_i = 0;
        check_all(req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        m_pc = 32'h0; m_depth = 0; m_exc = 0; m_ovf = 0;
        for (int i = 0; i < 8; i++) m_areg[i] = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check_all("R10");
        for (int i = 0; i < 8; i++) begin
            areg_rsel_i = 3'(i);
            #1 check("R10 areg", areg_rdata_o, 32'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R10 after release");

        // R4: address-register update regardless of condition
        for (int i = 0; i < 8; i++) begin
            exec(1'(i % 2), 0, 0, 0, '0, 32'h100 * (i + 1), 0, 16'h0,
                 1, 3'(i), 32'hA000_0000 + 32'(i * 7), "R4 exec");
            if (m_depth > 0) do_pop(0, "R9 drain");
        end
        for (int i = 0; i < 8; i++) begin
            areg_rsel_i = 3'(i);
            #1 check("R4 areg readback", areg_rdata_o, m_areg[i]);
        end

        // R1 R2 R3 R5 R6 R7: sweep all flag/mode combinations, aware-only first
        for (int n = 0; n < 2; n++) begin
            for (int combo = 0; combo < 32; combo++) begin
                logic c, na, nn, sh, ex;
                logic [14:0] imm;
                {nn, na, c, sh, ex} = 5'(combo);
                if (n == 0 && nn && na) continue;
                imm = (combo % 3 == 0) ? 15'h4000 + 15'(combo) : 15'h0123 + 15'(combo);
                exec(c, na, nn, sh, imm, 32'h8000_0000 + 32'(combo * 16), ex,
                     16'h3A50 ^ 16'(combo * 257), 0, 3'd0, 32'd0,
                     c ? (sh ? "R2 short R1 R5" : "R2 full R1 R5") : "R3 R7");
                if (m_depth >= 12) begin
                    while (m_depth > 0) do_pop(0, "R9 LIFO");
                end
            end
        end
        check("R6 flags raised", 32'(exc_o), 32'h3);

        // R11: valid low, instruction inputs toggle
        for (int i = 0; i < 4; i++) begin
            cond_i = 1; nonaware_i = 1; nan_i = 1; ea_i = 32'hDEAD_0000 + 32'(i);
            areg_we_i = 1; areg_sel_i = 3'(i); areg_val_i = 32'hFFFF_FFFF;
            @(negedge clk);
            check_all("R11 idle");
            areg_rsel_i = 3'(i);
            #1 check("R11 areg held", areg_rdata_o, m_areg[i]);
        end
        areg_we_i = 0;

        // R8: fill the stack, then one more taken call
        while (m_depth < DEPTH)
            exec(1, 0, 0, 0, '0, 32'h0000_1000 + 32'(m_depth), 0, 16'h000F, 0, 0, 0, "R1 fill");
        exec(1, 0, 0, 1, 15'h7FF0, 32'h0, 0, 16'h1234, 0, 0, 0, "R8 overflow");
        exec(1, 0, 0, 0, '0, 32'h5555_0000, 1, 16'h1234, 0, 0, 0, "R8 overflow again");

        // R9: pop with valid high ignored, then drain, then pop on empty
        do_pop(1, "R9 pop with valid");
        while (m_depth > 0) do_pop(0, "R9 drain LIFO");
        do_pop(0, "R9 empty pop");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule